// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the instruction address of a small microcontroller core whose program memory is split into pages of 512 words. On every instruction cycle it loads one new address into its program counter. The address is the old value plus one, an absolute jump target, a subroutine entry target, a computed-jump target built from a byte written into the counter's low byte, or a return address handed in by an external return stack. The jump target fills nine address bits. The subroutine entry and the computed jump fill only eight bits and force the ninth bit to zero, so both can reach only the lower half of a page. The page bit above the nine-bit field always comes from a page-select input, which a status register outside the block provides.

After reset the counter points at the very last word of program memory. The word stored there is expected to load a calibration constant. Once that instruction runs, the counter wraps to address zero and user code starts. The block also gives out the current address plus one as a combinational value, so a return stack can push it in the same cycle as a call. Instruction decoding, the status register and the return stack are outside this block. The status register is expected to clear its page-select bit on reset, which keeps early jumps inside page 0.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes all ones (0x3FF with the default 10-bit width). Reset is synchronous and active-high.
- R2: With no strobe high, `pc` advances by one on each clock edge, and 0x3FF wraps to 0x000. The first cycle after reset therefore lands on address 0.
- R3: When `jump_en` is the highest-priority strobe, the next `pc` takes bits 8:0 from `addr_field` and bit 9 from `page_sel`.
- R4: When `call_en` is the highest-priority strobe, the next `pc` takes bits 7:0 from `addr_field[7:0]`, bit 8 is 0 whatever `addr_field[8]` holds, and bit 9 comes from `page_sel`.
- R5: When `low_wr_en` is the only strobe high, the next `pc` takes bits 7:0 from `low_data`, bit 8 is 0, and bit 9 comes from `page_sel`.
- R6: When `ret_en` is high and `rst` is low, the next `pc` equals `ret_addr` bit for bit.
- R7: When several strobes are high at once, one source wins in this order: `ret_en`, then `call_en`, then `jump_en`, then `low_wr_en`, then increment.
- R8: `pc_next_seq` always equals `pc` plus one, modulo 1024, in the same cycle. It is combinational, with no register between `pc` and this output.
- R9: `rst` overrides every strobe: with all strobes high and `rst` high, `pc` still becomes 0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_en | input | 1 | Load the return address |
| ret_addr | input | 10 | Full return address from the external stack |
| call_en | input | 1 | Subroutine entry strobe |
| jump_en | input | 1 | Absolute jump strobe |
| low_wr_en | input | 1 | Low-byte write strobe (computed jump) |
| addr_field | input | 9 | Address field of the instruction word |
| low_data | input | 8 | Data byte written to the low byte |
| page_sel | input | 1 | Page-select bit from the status register |
| pc | output | 10 | Current program counter |
| pc_next_seq | output | 10 | pc plus one, for pushing on a call |

## Verification
The jump strobe is swept over every 9-bit field value with both page-select values. This confirms that bit 8 passes through and that the page bit lands above it. The call strobe gets the same full 9-bit sweep, and the half where field bit 8 is set shows that bit 8 is forced low instead of copied. Each of the 256 low-byte values is written with both page values while a non-zero junk field is applied, and every 10-bit return address is loaded, so each source is separated from its neighbours. A run of more than 1024 free increments from the reset vector shows the wrap to zero, and all 16 strobe combinations, plus reset with every strobe high, settle the priority order.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int unsigned PC_W_DEF  = 10;
    localparam int unsigned JMP_W_DEF = 9;
    localparam int unsigned LOW_W_DEF = 8;

    typedef enum logic [2:0] {
        SRC_INC  = 3'd0,
        SRC_LOW  = 3'd1,
        SRC_JUMP = 3'd2,
        SRC_CALL = 3'd3,
        SRC_RET  = 3'd4
    } pc_src_e;

    typedef struct packed {
        logic ret;
        logic call;
        logic jump;
        logic low_wr;
    } strobe_t;

    function automatic pc_src_e pick_source(input strobe_t s);
        pc_src_e r;
        if (s.ret)         r = SRC_RET;
        else if (s.call)   r = SRC_CALL;
        else if (s.jump)   r = SRC_JUMP;
        else if (s.low_wr) r = SRC_LOW;
        else               r = SRC_INC;
        return r;
    endfunction

endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  strobe_t strobes,
    output pc_src_e src
);
    always_comb begin
        src = pick_source(strobes);
    end
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target #(
    parameter int unsigned PC_W  = pcseq_pkg::PC_W_DEF,
    parameter int unsigned JMP_W = pcseq_pkg::JMP_W_DEF,
    parameter int unsigned LOW_W = pcseq_pkg::LOW_W_DEF
) (
    input  logic [JMP_W-1:0]      addr_field,
    input  logic [LOW_W-1:0]      low_data,
    input  logic [PC_W-JMP_W-1:0] page_sel,
    output logic [PC_W-1:0]       jump_addr,
    output logic [PC_W-1:0]       call_addr,
    output logic [PC_W-1:0]       low_addr
);
    localparam int unsigned PAGE_W = PC_W - JMP_W;
    localparam int unsigned GAP_W  = JMP_W - LOW_W;

    logic [GAP_W-1:0] gap_zero;
    assign gap_zero = '0;

    always_comb begin
        jump_addr = {page_sel, addr_field};
        call_addr = {page_sel, gap_zero, addr_field[LOW_W-1:0]};
        low_addr  = {page_sel, gap_zero, low_data};
    end

    if (PAGE_W < 1 || GAP_W < 1) begin : g_bad_cfg
        initial $display("pcseq_target: widths need PC_W > JMP_W > LOW_W");
    end
endmodule

// File: rtl/pcseq_pcreg.sv
module pcseq_pcreg
    import pcseq_pkg::*;
#(
    parameter int unsigned PC_W = pcseq_pkg::PC_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  pc_src_e         src,
    input  logic [PC_W-1:0] ret_addr,
    input  logic [PC_W-1:0] call_addr,
    input  logic [PC_W-1:0] jump_addr,
    input  logic [PC_W-1:0] low_addr,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] pc_inc
);
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;

    always_comb begin
        pc_inc = pc_q + PC_W'(1);
    end

    always_comb begin
        unique case (src)
            SRC_RET:  pc_d = ret_addr;
            SRC_CALL: pc_d = call_addr;
            SRC_JUMP: pc_d = jump_addr;
            SRC_LOW:  pc_d = low_addr;
            default:  pc_d = pc_inc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '1;
        else     pc_q <= pc_d;
    end

    assign pc = pc_q;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int unsigned PC_W  = pcseq_pkg::PC_W_DEF,
    parameter int unsigned JMP_W = pcseq_pkg::JMP_W_DEF,
    parameter int unsigned LOW_W = pcseq_pkg::LOW_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ret_en,
    input  logic [PC_W-1:0]       ret_addr,
    input  logic                  call_en,
    input  logic                  jump_en,
    input  logic                  low_wr_en,
    input  logic [JMP_W-1:0]      addr_field,
    input  logic [LOW_W-1:0]      low_data,
    input  logic [PC_W-JMP_W-1:0] page_sel,
    output logic [PC_W-1:0]       pc,
    output logic [PC_W-1:0]       pc_next_seq
);
    strobe_t         strobes;
    pc_src_e         src;
    logic [PC_W-1:0] jump_addr;
    logic [PC_W-1:0] call_addr;
    logic [PC_W-1:0] low_addr;

    assign strobes = '{ret: ret_en, call: call_en, jump: jump_en, low_wr: low_wr_en};

    pcseq_arbiter u_arb (
        .strobes (strobes),
        .src     (src)
    );

    pcseq_target #(.PC_W(PC_W), .JMP_W(JMP_W), .LOW_W(LOW_W)) u_tgt (
        .addr_field (addr_field),
        .low_data   (low_data),
        .page_sel   (page_sel),
        .jump_addr  (jump_addr),
        .call_addr  (call_addr),
        .low_addr   (low_addr)
    );

    pcseq_pcreg #(.PC_W(PC_W)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .src       (src),
        .ret_addr  (ret_addr),
        .call_addr (call_addr),
        .jump_addr (jump_addr),
        .low_addr  (low_addr),
        .pc        (pc),
        .pc_inc    (pc_next_seq)
    );
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
    parameter int unsigned PC_W  = 10,
    parameter int unsigned JMP_W = 9,
    parameter int unsigned LOW_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ret_en,
    input logic [PC_W-1:0]       ret_addr,
    input logic                  call_en,
    input logic                  jump_en,
    input logic                  low_wr_en,
    input logic [JMP_W-1:0]      addr_field,
    input logic [LOW_W-1:0]      low_data,
    input logic [PC_W-JMP_W-1:0] page_sel,
    input logic [PC_W-1:0]       pc,
    input logic [PC_W-1:0]       pc_next_seq
);
    logic quiet;
    assign quiet = !ret_en && !call_en && !jump_en && !low_wr_en;

    // R1 and R9: reset wins over every strobe
    a_r1_reset_vector: assert property (@(posedge clk)
        rst |=> (pc == {PC_W{1'b1}}));

    // R2: free-running advance
    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        quiet |=> (pc == PC_W'($past(pc) + PC_W'(1))));

    // R8: the plus-one output is what the counter moves to on a quiet cycle
    a_r8_inc_matches_next: assert property (@(posedge clk) disable iff (rst)
        quiet |=> (pc == $past(pc_next_seq)));

    // R3
    a_r3_jump_target: assert property (@(posedge clk) disable iff (rst)
        (jump_en && !ret_en && !call_en) |=>
            (pc == {$past(page_sel), $past(addr_field)}));

    // R4: bit 8 forced low on a call
    a_r4_call_low_half: assert property (@(posedge clk) disable iff (rst)
        (call_en && !ret_en) |=>
            (pc[LOW_W-1:0] == $past(addr_field[LOW_W-1:0]) &&
             pc[JMP_W-1:LOW_W] == '0 &&
             pc[PC_W-1:JMP_W] == $past(page_sel)));

    // R5
    a_r5_low_write: assert property (@(posedge clk) disable iff (rst)
        (low_wr_en && !ret_en && !call_en && !jump_en) |=>
            (pc[LOW_W-1:0] == $past(low_data) &&
             pc[JMP_W-1:LOW_W] == '0 &&
             pc[PC_W-1:JMP_W] == $past(page_sel)));

    // R6 and R7: return beats all other strobes
    a_r6_return_load: assert property (@(posedge clk) disable iff (rst)
        ret_en |=> (pc == $past(ret_addr)));
endmodule

bind pc_sequencer pcseq_checker #(.PC_W(PC_W), .JMP_W(JMP_W), .LOW_W(LOW_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ret_en      (ret_en),
    .ret_addr    (ret_addr),
    .call_en     (call_en),
    .jump_en     (jump_en),
    .low_wr_en   (low_wr_en),
    .addr_field  (addr_field),
    .low_data    (low_data),
    .page_sel    (page_sel),
    .pc          (pc),
    .pc_next_seq (pc_next_seq)
);

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ret_en = 1'b0;
    logic [9:0] ret_addr = '0;
    logic       call_en = 1'b0;
    logic       jump_en = 1'b0;
    logic       low_wr_en = 1'b0;
    logic [8:0] addr_field = '0;
    logic [7:0] low_data = '0;
    logic [0:0] page_sel = '0;
    logic [9:0] pc;
    logic [9:0] pc_next_seq;

    int checks = 0;
    int errors = 0;
    int exp_pc = 0;

    always #(PERIOD/2) clk = ~clk;

    pc_sequencer u0 (
        .clk(clk), .rst(rst), .ret_en(ret_en), .ret_addr(ret_addr),
        .call_en(call_en), .jump_en(jump_en), .low_wr_en(low_wr_en),
        .addr_field(addr_field), .low_data(low_data), .page_sel(page_sel),
        .pc(pc), .pc_next_seq(pc_next_seq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic rt, input logic cl,
                         input logic jp, input logic wr, input int ra,
                         input int fld, input int dat, input int pg);
        rst = r; ret_en = rt; call_en = cl; jump_en = jp; low_wr_en = wr;
        ret_addr = 10'(ra); addr_field = 9'(fld); low_data = 8'(dat);
        page_sel = 1'(pg);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset vector and R8 at the top of memory
        repeat (2) @(negedge clk);
        chk("R1 reset vector", pc, 1023);
        chk("R8 plus-one wraps", pc_next_seq, 0);
        exp_pc = 1023;

        // R2: free increment walk through the wrap
        for (int i = 0; i < 1030; i++) begin
            drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
            exp_pc = (exp_pc + 1) % 1024;
            chk("R2 increment", pc, exp_pc);
            chk("R8 plus-one", pc_next_seq, (exp_pc + 1) % 1024);
        end

        // R3: jump over every field and both pages
        for (int pg = 0; pg < 2; pg++)
            for (int f = 0; f < 512; f++) begin
                drive(0, 0, 0, 1, 0, 0, f, 0, pg);
                chk("R3 jump", pc, pg * 512 + f);
            end

        // R4: call with every 9-bit field, bit 8 dropped
        for (int pg = 0; pg < 2; pg++)
            for (int f = 0; f < 512; f++) begin
                drive(0, 0, 1, 0, 0, 0, f, 0, pg);
                chk("R4 call", pc, pg * 512 + (f % 256));
            end

        // R5: low-byte write with junk on the field
        for (int pg = 0; pg < 2; pg++)
            for (int d = 0; d < 256; d++) begin
                drive(0, 0, 0, 0, 1, 0, 9'h1AA, d, pg);
                chk("R5 low write", pc, pg * 512 + d);
            end

        // R6: every return address
        for (int a = 0; a < 1024; a++) begin
            drive(0, 1, 0, 0, 0, a, 9'h155, 8'h33, a % 2);
            chk("R6 return", pc, a);
        end

        // R7: all strobe combinations
        exp_pc = pc;
        for (int m = 0; m < 16; m++) begin
            int e;
            if (m[3])      e = 10'h2A5;
            else if (m[2]) e = 512 + 8'hC3;
            else if (m[1]) e = 512 + 9'h1C3;
            else if (m[0]) e = 512 + 8'h5E;
            else           e = (exp_pc + 1) % 1024;
            drive(0, m[3], m[2], m[1], m[0], 10'h2A5, 9'h1C3, 8'h5E, 1);
            chk("R7 priority", pc, e);
            exp_pc = e;
        end

        // R9: reset with every strobe high
        drive(1, 1, 1, 1, 1, 10'h123, 9'h0F0, 8'h0F, 1);
        chk("R9 reset override", pc, 1023);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R2 first step after reset", pc, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule